// File: doc/BRIEF.md
# Width-Selectable Up/Down Counter with Compare, Interrupt Flags and PWM

This block is a general-purpose event and timer counter for a low-power controller. A count register of `CNT_W` bits (10 by default) steps up or down once for each tick of a selected source. The source is one of eight. Six are enable ticks from a prescaler. The other two are rising edges seen on two external event inputs. All sources are sampled on the single system clock, and no clock is gated.

The active length can be cut from the full width down to three shorter widths, each `LIM_STEP` bits shorter than the one before. Bits above the active length are held at zero, and the count wraps at the active length.

Software can load a start value in parallel and write a compare value. The compare can match all `CNT_W` bits or only the active bits. Two sticky flags report a compare hit and a step onto zero. A PWM output rises when the count wraps or is loaded, and falls on a compare hit. While counting up, the fraction of time it stays high is the compare value divided by the active range.

Top module: `updn_pwm_counter`

## Requirements
- R1: `width_sel_i` picks the active length: 0 = `CNT_W`, 1 = `CNT_W`-2, 2 = `CNT_W`-4, 3 = `CNT_W`-6 bits (10/8/6/4 by default). Bits of `count_o` above the active length read zero from the cycle after any change of `width_sel_i` onward.
- R2: With `dir_up_i`=1 each counted tick adds one, and the all-ones value of the active length steps to zero. With `dir_up_i`=0 each counted tick subtracts one, and zero steps to the active all-ones value.
- R3: `src_sel_i` values 0 to 5 select bit `src_sel_i` of `pre_tick_i`. Value 6 selects a rising edge of `ev_a_i` and value 7 selects a rising edge of `ev_b_i`. The count moves by one only in a cycle where the selected source is active and `run_i`=1. Unselected sources, an event input that stays high, and any tick while `run_i`=0 all leave the count unchanged.
- R4: `load_i`=1 places `data_i` masked to the active length into the count on the next cycle. This takes precedence over a tick in the same cycle.
- R5: `cmp_wr_i`=1 stores `data_i` unmasked as the compare value. With `cmp_full_i`=1 a hit needs all `CNT_W` bits of the new count to equal the compare value. With `cmp_full_i`=0 only the active bits are compared.
- R6: `irq_cmp_o` becomes 1 in the cycle after a counted step lands on a compare hit, and stays 1 until `clr_cmp_i`. A hit in the same cycle as `clr_cmp_i` leaves the flag set.
- R7: `irq_zero_o` becomes 1 in the cycle after a counted step lands on zero, and stays 1 until `clr_zero_i`. A load of zero does not set it.
- R8: `pwm_o` goes to 1 after a load or a wrap. A wrap is a step onto zero when counting up, or onto the active all-ones value when counting down. `pwm_o` goes to 0 after a compare hit, and a hit wins over a wrap in the same step. When counting up on every cycle, `pwm_o` is high for exactly compare-value cycles of each period of 2^length cycles.
- R9: After reset the count, the compare value, both flags and `pwm_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pre_tick_i | input | 6 | Prescaler enable ticks, sources 0 to 5 |
| ev_a_i | input | 1 | External event input, source 6 (rising edge) |
| ev_b_i | input | 1 | External event input, source 7 (rising edge) |
| src_sel_i | input | 3 | Count source select |
| run_i | input | 1 | Counting enable |
| dir_up_i | input | 1 | 1 = count up, 0 = count down |
| width_sel_i | input | 2 | Active length select |
| load_i | input | 1 | Parallel load strobe |
| cmp_wr_i | input | 1 | Compare value write strobe |
| data_i | input | 10 | Load or compare data |
| cmp_full_i | input | 1 | 1 = compare all bits, 0 = active bits only |
| clr_cmp_i | input | 1 | Clear compare flag |
| clr_zero_i | input | 1 | Clear zero flag |
| count_o | output | 10 | Current count |
| irq_cmp_o | output | 1 | Compare hit flag |
| irq_zero_o | output | 1 | Zero reached flag |
| pwm_o | output | 1 | PWM output |

## Verification
Every result appears exactly one clock after the input that causes it: the count, both flags and `pwm_o` are registered straight from the cycle's inputs. The event edge detector compares against the previous cycle's level, so it adds no extra delay. The bench changes inputs only just after a falling edge and reads the outputs at the next falling edge, one rising edge later. Multi-cycle results, such as the PWM high time, are counted over a whole period of samples taken one per cycle.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    typedef enum logic [1:0] {
        WM_FULL = 2'd0,
        WM_LIM1 = 2'd1,
        WM_LIM2 = 2'd2,
        WM_LIM3 = 2'd3
    } wmode_e;

    // Ones in the low (full_w - step*mode) bits.
    function automatic logic [31:0] active_mask(input int full_w, input int step,
                                                input logic [1:0] mode);
        logic [31:0] m;
        int          w;
        w = full_w - step * int'(mode);
        for (int i = 0; i < 32; i++) begin
            m[i] = (i < w);
        end
        return m;
    endfunction

endpackage

// File: rtl/cnt_src_sel.sv
module cnt_src_sel #(
    parameter int N_PRE = 6,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_PRE-1:0] pre_tick_i,
    input  logic             ev_a_i,
    input  logic             ev_b_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int N_SRC = N_PRE + 2;

    typedef struct packed {
        logic ev_a;
        logic ev_b;
    } sel_state_t;

    sel_state_t       s_d, s_q;
    logic [N_SRC-1:0] srcs;

    always_comb begin
        s_d      = s_q;
        s_d.ev_a = ev_a_i;
        s_d.ev_b = ev_b_i;
        srcs     = {ev_b_i & ~s_q.ev_b, ev_a_i & ~s_q.ev_a, pre_tick_i};
        tick_o   = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (int'(sel_i) == i) begin
                tick_o = srcs[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/cnt_core.sv
module cnt_core #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] mask_i,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             up_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] data_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] nxt_o,
    output logic             step_o,
    output logic             wrap_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } core_state_t;

    core_state_t s_d, s_q;
    logic        step;

    always_comb begin
        s_d  = s_q;
        step = run_i & tick_i & ~load_i;
        if (load_i) begin
            s_d.cnt = data_i & mask_i;
        end else if (step) begin
            if (up_i) begin
                s_d.cnt = (s_q.cnt + 1'b1) & mask_i;
            end else begin
                s_d.cnt = (s_q.cnt - 1'b1) & mask_i;
            end
        end else begin
            s_d.cnt = s_q.cnt & mask_i;
        end
        nxt_o  = s_d.cnt;
        step_o = step;
        wrap_o = step & (up_i ? (s_d.cnt == '0) : (s_d.cnt == mask_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o = s_q.cnt;

endmodule

// File: rtl/cnt_evt.sv
module cnt_evt #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] mask_i,
    input  logic [CNT_W-1:0] nxt_i,
    input  logic             step_i,
    input  logic             wrap_i,
    input  logic             load_i,
    input  logic             cmp_wr_i,
    input  logic [CNT_W-1:0] data_i,
    input  logic             cmp_full_i,
    input  logic             clr_cmp_i,
    input  logic             clr_zero_i,
    output logic             irq_cmp_o,
    output logic             irq_zero_o,
    output logic             pwm_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cmp;
        logic             f_cmp;
        logic             f_zero;
        logic             pwm;
    } evt_state_t;

    evt_state_t s_d, s_q;
    logic       match, hit, at_zero;

    always_comb begin
        s_d = s_q;
        if (cmp_full_i) begin
            match = (nxt_i == s_q.cmp);
        end else begin
            match = ((nxt_i & mask_i) == (s_q.cmp & mask_i));
        end
        hit     = step_i & match;
        at_zero = step_i & (nxt_i == '0);

        if (cmp_wr_i) begin
            s_d.cmp = data_i;
        end
        s_d.f_cmp  = (s_q.f_cmp & ~clr_cmp_i) | hit;
        s_d.f_zero = (s_q.f_zero & ~clr_zero_i) | at_zero;

        if (load_i) begin
            s_d.pwm = 1'b1;
        end else if (hit) begin
            s_d.pwm = 1'b0;
        end else if (wrap_i) begin
            s_d.pwm = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq_cmp_o  = s_q.f_cmp;
    assign irq_zero_o = s_q.f_zero;
    assign pwm_o      = s_q.pwm;

endmodule

// File: rtl/updn_pwm_counter.sv
module updn_pwm_counter #(
    parameter int CNT_W    = 10,
    parameter int LIM_STEP = 2,
    parameter int N_PRE    = 6,
    parameter int SEL_W    = $clog2(N_PRE + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_PRE-1:0] pre_tick_i,
    input  logic             ev_a_i,
    input  logic             ev_b_i,
    input  logic [SEL_W-1:0] src_sel_i,
    input  logic             run_i,
    input  logic             dir_up_i,
    input  logic [1:0]       width_sel_i,
    input  logic             load_i,
    input  logic             cmp_wr_i,
    input  logic [CNT_W-1:0] data_i,
    input  logic             cmp_full_i,
    input  logic             clr_cmp_i,
    input  logic             clr_zero_i,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_cmp_o,
    output logic             irq_zero_o,
    output logic             pwm_o
);
    logic [31:0]      mask_w;
    logic [CNT_W-1:0] mask;
    logic [CNT_W-1:0] nxt;
    logic             tick, step, wrap;

    assign mask_w = cnt_pkg::active_mask(CNT_W, LIM_STEP, width_sel_i);
    assign mask   = mask_w[CNT_W-1:0];

    cnt_src_sel #(.N_PRE(N_PRE), .SEL_W(SEL_W)) u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .pre_tick_i (pre_tick_i),
        .ev_a_i     (ev_a_i),
        .ev_b_i     (ev_b_i),
        .sel_i      (src_sel_i),
        .tick_o     (tick)
    );

    cnt_core #(.CNT_W(CNT_W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .mask_i (mask),
        .run_i  (run_i),
        .tick_i (tick),
        .up_i   (dir_up_i),
        .load_i (load_i),
        .data_i (data_i),
        .cnt_o  (count_o),
        .nxt_o  (nxt),
        .step_o (step),
        .wrap_o (wrap)
    );

    cnt_evt #(.CNT_W(CNT_W)) u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_i     (mask),
        .nxt_i      (nxt),
        .step_i     (step),
        .wrap_i     (wrap),
        .load_i     (load_i),
        .cmp_wr_i   (cmp_wr_i),
        .data_i     (data_i),
        .cmp_full_i (cmp_full_i),
        .clr_cmp_i  (clr_cmp_i),
        .clr_zero_i (clr_zero_i),
        .irq_cmp_o  (irq_cmp_o),
        .irq_zero_o (irq_zero_o),
        .pwm_o      (pwm_o)
    );

endmodule

// File: rtl/updn_pwm_counter_chk.sv
module updn_pwm_counter_chk #(
    parameter int CNT_W    = 10,
    parameter int LIM_STEP = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       width_sel_i,
    input logic             load_i,
    input logic             run_i,
    input logic [CNT_W-1:0] data_i,
    input logic             clr_cmp_i,
    input logic             clr_zero_i,
    input logic [CNT_W-1:0] count_o,
    input logic             irq_cmp_o,
    input logic             irq_zero_o,
    input logic             pwm_o
);
    function automatic logic [CNT_W-1:0] msk(input logic [1:0] s);
        logic [31:0] t;
        t = cnt_pkg::active_mask(CNT_W, LIM_STEP, s);
        return t[CNT_W-1:0];
    endfunction

    a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((count_o & ~msk($past(width_sel_i))) == '0));

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !run_i) |=> (count_o == ($past(count_o) & msk($past(width_sel_i)))));

    a_r4_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (count_o == ($past(data_i) & msk($past(width_sel_i)))));

    a_r6_cmp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_cmp_o && !clr_cmp_i) |=> irq_cmp_o);

    a_r7_zero_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_zero_o && !clr_zero_i) |=> irq_zero_o);

    a_r8_pwm_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> pwm_o);

endmodule

bind updn_pwm_counter updn_pwm_counter_chk #(.CNT_W(CNT_W), .LIM_STEP(LIM_STEP)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .width_sel_i (width_sel_i),
    .load_i      (load_i),
    .run_i       (run_i),
    .data_i      (data_i),
    .clr_cmp_i   (clr_cmp_i),
    .clr_zero_i  (clr_zero_i),
    .count_o     (count_o),
    .irq_cmp_o   (irq_cmp_o),
    .irq_zero_o  (irq_zero_o),
    .pwm_o       (pwm_o)
);

// File: tb/updn_pwm_counter_bench.sv
module updn_pwm_counter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] pre_tick = '0;
    logic       ev_a = 1'b0, ev_b = 1'b0;
    logic [2:0] src_sel = '0;
    logic       run = 1'b0, dir_up = 1'b1;
    logic [1:0] width_sel = '0;
    logic       load = 1'b0, cmp_wr = 1'b0, cmp_full = 1'b0;
    logic [9:0] data = '0;
    logic       clr_cmp = 1'b0, clr_zero = 1'b0;
    logic [9:0] count;
    logic       irq_cmp, irq_zero, pwm;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    updn_pwm_counter u_updn_pwm_counter (
        .clk(clk), .rst_n(rst_n), .pre_tick_i(pre_tick), .ev_a_i(ev_a), .ev_b_i(ev_b),
        .src_sel_i(src_sel), .run_i(run), .dir_up_i(dir_up), .width_sel_i(width_sel),
        .load_i(load), .cmp_wr_i(cmp_wr), .data_i(data), .cmp_full_i(cmp_full),
        .clr_cmp_i(clr_cmp), .clr_zero_i(clr_zero), .count_o(count),
        .irq_cmp_o(irq_cmp), .irq_zero_o(irq_zero), .pwm_o(pwm)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic do_load(input logic [9:0] v);
        data = v; load = 1'b1; cyc(); load = 1'b0;
    endtask

    task automatic wr_cmp(input logic [9:0] v);
        data = v; cmp_wr = 1'b1; cyc(); cmp_wr = 1'b0;
    endtask

    task automatic tick0();
        pre_tick[0] = 1'b1; cyc(); pre_tick[0] = 1'b0;
    endtask

    task automatic clear_flags();
        clr_cmp = 1'b1; clr_zero = 1'b1; cyc(); clr_cmp = 1'b0; clr_zero = 1'b0;
    endtask

    task automatic t_reset();
        check("R9 count", count, 0);
        check("R9 irq_cmp", irq_cmp, 0);
        check("R9 irq_zero", irq_zero, 0);
        check("R9 pwm", pwm, 0);
    endtask

    task automatic t_up_full();
        width_sel = 2'd0; dir_up = 1'b1; src_sel = 3'd0; run = 1'b1;
        clear_flags();
        do_load(10'h3FE);
        check("R4 load", count, 10'h3FE);
        tick0();
        check("R2 up step", count, 10'h3FF);
        check("R7 no zero yet", irq_zero, 0);
        tick0();
        check("R2 up wrap", count, 0);
        check("R7 zero flag", irq_zero, 1);
    endtask

    task automatic t_down_lim();
        width_sel = 2'd3; dir_up = 1'b0; run = 1'b1;
        clear_flags();
        do_load(10'h3F2);
        check("R1 load masked", count, 2);
        tick0(); check("R2 down", count, 1);
        tick0(); check("R2 down to zero", count, 0);
        check("R7 zero flag down", irq_zero, 1);
        clear_flags();
        tick0(); check("R2 down wrap", count, 10'h00F);
        check("R8 pwm set on down wrap", pwm, 1);
        dir_up = 1'b1;
    endtask

    task automatic t_width_trunc();
        width_sel = 2'd0; run = 1'b0;
        do_load(10'h2AB);
        check("R4 load full", count, 10'h2AB);
        width_sel = 2'd2; cyc();
        check("R1 truncate to 6 bits", count, 10'h02B);
        width_sel = 2'd1; cyc();
        check("R1 hold at 8 bits", count, 10'h02B);
    endtask

    task automatic t_sources();
        width_sel = 2'd0; dir_up = 1'b1; run = 1'b1;
        do_load(10'h010);
        src_sel = 3'd3;
        pre_tick[2] = 1'b1; cyc(); pre_tick[2] = 1'b0;
        check("R3 unselected tick ignored", count, 10'h010);
        pre_tick[3] = 1'b1; cyc(); pre_tick[3] = 1'b0;
        check("R3 selected tick", count, 10'h011);
        src_sel = 3'd6;
        ev_a = 1'b1; cyc();
        check("R3 ev_a edge", count, 10'h012);
        cyc();
        check("R3 ev_a level held", count, 10'h012);
        ev_a = 1'b0; ev_b = 1'b1; cyc();
        check("R3 ev_b not selected", count, 10'h012);
        ev_b = 1'b0; cyc();
        src_sel = 3'd7; ev_b = 1'b1; cyc(); ev_b = 1'b0;
        check("R3 ev_b edge", count, 10'h013);
        src_sel = 3'd0; run = 1'b0; tick0();
        check("R3 run low ignores tick", count, 10'h013);
        run = 1'b1;
        data = 10'h100; load = 1'b1; pre_tick[0] = 1'b1; cyc();
        load = 1'b0; pre_tick[0] = 1'b0;
        check("R4 load over tick", count, 10'h100);
    endtask

    task automatic t_compare();
        width_sel = 2'd3; dir_up = 1'b1; run = 1'b1; src_sel = 3'd0;
        cmp_full = 1'b0;
        wr_cmp(10'h105);
        clear_flags();
        do_load(3);
        tick0(); check("R5 no hit at 4", irq_cmp, 0);
        tick0(); check("R5 limited hit at 5", irq_cmp, 1);
        check("R8 pwm low after hit", pwm, 0);
        clear_flags(); check("R6 cleared", irq_cmp, 0);
        do_load(4);
        clr_cmp = 1'b1; pre_tick[0] = 1'b1; cyc(); clr_cmp = 1'b0; pre_tick[0] = 1'b0;
        check("R6 hit wins over clear", irq_cmp, 1);
        clear_flags();
        cmp_full = 1'b1;
        do_load(4);
        tick0(); check("R5 full compare no hit", irq_cmp, 0);
        cmp_full = 1'b0;
        clear_flags();
        do_load(0);
        check("R7 load zero no flag", irq_zero, 0);
    endtask

    task automatic t_pwm(input int cval);
        int hi1, hi2;
        width_sel = 2'd3; dir_up = 1'b1; run = 1'b1; src_sel = 3'd0; cmp_full = 1'b0;
        wr_cmp(10'(cval));
        do_load(0);
        check("R8 pwm after load", pwm, 1);
        pre_tick[0] = 1'b1;
        hi1 = 0; hi2 = 0;
        for (int i = 0; i < 16; i++) begin cyc(); hi1 += int'(pwm); end
        for (int i = 0; i < 16; i++) begin cyc(); hi2 += int'(pwm); end
        pre_tick[0] = 1'b0;
        if (cval != 0) check("R8 duty first period", hi1, cval);
        check("R8 duty steady period", hi2, cval);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cyc(); cyc();
        t_reset();
        rst_n = 1'b1; cyc();
        t_reset();
        t_up_full();
        t_down_lim();
        t_width_trunc();
        t_sources();
        t_compare();
        t_pwm(4);
        t_pwm(12);
        t_pwm(0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule